// File: doc/BRIEF.md
# Pad-Inserting Byte Ordering Unit

This block sits on the receive path after the 8b/10b decoder and a 2:1 deserializer. Each cycle it takes a 32-bit word made of four byte lanes, with one control flag per lane, plus the word-aligner sync flag. Its job is to put the ordering character (a control character, by default K28.5) into the least-significant byte lane. Lane 0 is data bits 7:0 with flag bit 0. Lane 2 is data bits 23:16 with flag bit 2, and it is the lowest lane of the upper half-word.

Once sync is present, the block searches each word for the ordering pattern. The pattern is 9 bits wide: the lane's control flag followed by its data byte. If the pattern arrives in lane 0, the block locks with words passed through unchanged. If it arrives in lane 2, the block inserts one pad half-word into the stream. From then on it emits the previous upper half-word below the current lower half-word. For example, a half-swapped arrival `0x4ABC7B4A` becomes the ordered `0x7B4A4ABC`. A status flag reports that ordering has been reached. Losing sync clears the offset and the status.

Top module: `lane_order_pad`

## Requirements
- R1: A lane matches only when its flag and byte together equal the 9-bit PATTERN parameter (default 0x1BC: flag set, byte 0xBC). A 0xBC byte whose flag is clear is treated as plain data.
- R2: While `in_sync` is low, no search takes place. The word is passed through unchanged and `ordered` is low.
- R3: When the block is searching and lane 0 matches, the word passes through unchanged, and `ordered` rises on that same output word.
- R4: When the block is searching, lane 2 matches and lane 0 does not, that output word holds the input's lower half-word in its upper half. Its lower half is filled with pad lanes (PAD default 0x000: flag clear, byte 0x00), and `ordered` stays low.
- R5: After a pad insertion, every output word is {current lower half-word, previous upper half-word}. `ordered` rises on the first such word, which carries the pattern in lane 0.
- R6: When lane 0 and lane 2 both match during a search, lane 0 wins and no pad is inserted.
- R7: Once `ordered` is high and sync stays up, the chosen offset is kept. A later pattern in any lane neither changes the offset nor clears `ordered`.
- R8: A word taken with `in_sync` low clears both the offset and `ordered` on its output. Searching begins again only after sync returns.
- R9: Every output word appears exactly one clock after the input word it derives from, with or without an offset.
- R10: While reset is asserted, `out_data` and `out_ctl` are zero and `ordered` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Half-rate receive clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_data | input | 32 | Decoded data, four byte lanes |
| in_ctl | input | 4 | Control flag per input lane |
| in_sync | input | 1 | Word-aligner sync status |
| out_data | output | 32 | Ordered data word |
| out_ctl | output | 4 | Control flag per output lane |
| ordered | output | 1 | Byte ordering reached |

## Verification
The hardest condition to reach from the ports is the shifted lock. The pad word must be produced first, and only then does the previous upper half show up in lane 0. The stimulus reaches it by dropping sync and then sending two half-swapped words, `0x4ABC7B4A` with flag `0100`. Counting data words follow, so that any mix-up of half-words between cycles shows in the output. Further stimulus covers sync dropping while in the shifted lock, a word where both lanes match, and a 0xBC byte with no flag.

// File: rtl/lane_order_pkg.sv
package lane_order_pkg;

    typedef enum logic [1:0] {
        ST_HUNT    = 2'd0,
        ST_PEND    = 2'd1,
        ST_LOCK_ST = 2'd2,
        ST_LOCK_SH = 2'd3
    } lo_state_e;

    typedef enum logic [1:0] {
        SEL_STRAIGHT = 2'd0,
        SEL_PAD      = 2'd1,
        SEL_SHIFT    = 2'd2
    } lo_sel_e;

endpackage

// File: rtl/lane_order_match.sv
module lane_order_match #(
    parameter int          LANE_W  = 8,
    parameter logic [LANE_W:0] PATTERN = 9'h1BC
) (
    input  logic [LANE_W-1:0] lane_data,
    input  logic              lane_flag,
    output logic              hit
);
    always_comb begin
        hit = ({lane_flag, lane_data} == PATTERN);
    end
endmodule

// File: rtl/lane_order_mux.sv
module lane_order_mux
    import lane_order_pkg::*;
#(
    parameter int          LANE_W = 8,
    parameter int          LANES  = 4,
    parameter logic [LANE_W:0] PAD = 9'h000,
    localparam int         DW     = LANE_W * LANES,
    localparam int         HL     = LANES / 2,
    localparam int         HW     = LANE_W * HL
) (
    input  logic [DW-1:0]    in_data,
    input  logic [LANES-1:0] in_ctl,
    input  logic [HW-1:0]    prev_data,
    input  logic [HL-1:0]    prev_ctl,
    input  lo_sel_e          sel,
    output logic [DW-1:0]    mux_data,
    output logic [LANES-1:0] mux_ctl
);
    logic [HW-1:0] pad_data;
    logic [HL-1:0] pad_ctl;

    for (genvar g = 0; g < HL; g++) begin : g_pad
        assign pad_data[g*LANE_W +: LANE_W] = PAD[LANE_W-1:0];
        assign pad_ctl[g]                   = PAD[LANE_W];
    end

    always_comb begin
        unique case (sel)
            SEL_PAD: begin
                mux_data = {in_data[HW-1:0], pad_data};
                mux_ctl  = {in_ctl[HL-1:0], pad_ctl};
            end
            SEL_SHIFT: begin
                mux_data = {in_data[HW-1:0], prev_data};
                mux_ctl  = {in_ctl[HL-1:0], prev_ctl};
            end
            default: begin
                mux_data = in_data;
                mux_ctl  = in_ctl;
            end
        endcase
    end
endmodule

// File: rtl/lane_order_pad.sv
module lane_order_pad
    import lane_order_pkg::*;
#(
    parameter int          LANE_W  = 8,
    parameter int          LANES   = 4,
    parameter logic [LANE_W:0] PATTERN = 9'h1BC,
    parameter logic [LANE_W:0] PAD     = 9'h000,
    localparam int         DW      = LANE_W * LANES,
    localparam int         HL      = LANES / 2,
    localparam int         HW      = LANE_W * HL
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DW-1:0]    in_data,
    input  logic [LANES-1:0] in_ctl,
    input  logic             in_sync,
    output logic [DW-1:0]    out_data,
    output logic [LANES-1:0] out_ctl,
    output logic             ordered
);
    typedef struct packed {
        lo_state_e        st;
        logic [HW-1:0]    prev_data;
        logic [HL-1:0]    prev_ctl;
        logic [DW-1:0]    odata;
        logic [LANES-1:0] octl;
        logic             ord;
    } regs_t;

    regs_t   r_q, r_d;
    lo_sel_e sel;
    lo_state_e st_next;
    logic    hit_lo, hit_hi, hit_prev;
    logic [DW-1:0]    mux_data;
    logic [LANES-1:0] mux_ctl;

    // lane 0 of the incoming word
    lane_order_match #(.LANE_W(LANE_W), .PATTERN(PATTERN)) u_match_lo (
        .lane_data (in_data[LANE_W-1:0]),
        .lane_flag (in_ctl[0]),
        .hit       (hit_lo)
    );

    // lowest lane of the incoming upper half
    lane_order_match #(.LANE_W(LANE_W), .PATTERN(PATTERN)) u_match_hi (
        .lane_data (in_data[HW +: LANE_W]),
        .lane_flag (in_ctl[HL]),
        .hit       (hit_hi)
    );

    // lowest lane of the held upper half (lane 0 of a shifted word)
    lane_order_match #(.LANE_W(LANE_W), .PATTERN(PATTERN)) u_match_prev (
        .lane_data (r_q.prev_data[LANE_W-1:0]),
        .lane_flag (r_q.prev_ctl[0]),
        .hit       (hit_prev)
    );

    lane_order_mux #(.LANE_W(LANE_W), .LANES(LANES), .PAD(PAD)) u_mux (
        .in_data   (in_data),
        .in_ctl    (in_ctl),
        .prev_data (r_q.prev_data),
        .prev_ctl  (r_q.prev_ctl),
        .sel       (sel),
        .mux_data  (mux_data),
        .mux_ctl   (mux_ctl)
    );

    // state decision and lane selection
    always_comb begin
        sel     = SEL_STRAIGHT;
        st_next = r_q.st;
        if (!in_sync) begin
            st_next = ST_HUNT;
        end else begin
            unique case (r_q.st)
                ST_HUNT: begin
                    if (hit_lo) begin
                        st_next = ST_LOCK_ST;
                    end else if (hit_hi) begin
                        sel     = SEL_PAD;
                        st_next = ST_PEND;
                    end
                end
                ST_PEND: begin
                    sel     = SEL_SHIFT;
                    st_next = hit_prev ? ST_LOCK_SH : ST_HUNT;
                end
                ST_LOCK_SH: sel = SEL_SHIFT;
                default:    sel = SEL_STRAIGHT;
            endcase
        end
    end

    // next register contents
    always_comb begin
        r_d           = r_q;
        r_d.st        = st_next;
        r_d.prev_data = in_data[DW-1:HW];
        r_d.prev_ctl  = in_ctl[LANES-1:HL];
        r_d.odata     = mux_data;
        r_d.octl      = mux_ctl;
        r_d.ord       = (st_next == ST_LOCK_ST) || (st_next == ST_LOCK_SH);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_HUNT, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign out_data = r_q.odata;
    assign out_ctl  = r_q.octl;
    assign ordered  = r_q.ord;
endmodule

// File: rtl/lane_order_chk.sv
module lane_order_chk #(
    parameter int          LANE_W  = 8,
    parameter int          LANES   = 4,
    parameter logic [LANE_W:0] PATTERN = 9'h1BC,
    localparam int         DW      = LANE_W * LANES
) (
    input logic             clk,
    input logic             rst_n,
    input logic [DW-1:0]    in_data,
    input logic [LANES-1:0] in_ctl,
    input logic             in_sync,
    input logic [DW-1:0]    out_data,
    input logic [LANES-1:0] out_ctl,
    input logic             ordered
);
    // R8
    sync_loss_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_sync |=> !ordered);

    // R2
    nosync_passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_sync |=> (out_data == $past(in_data)) && (out_ctl == $past(in_ctl)));

    // R3
    rise_on_pattern_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ordered) |-> ({out_ctl[0], out_data[LANE_W-1:0]} == PATTERN));

    // R7
    lock_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ordered && in_sync) |=> ordered);
endmodule

bind lane_order_pad lane_order_chk #(
    .LANE_W (LANE_W),
    .LANES  (LANES),
    .PATTERN(PATTERN)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_data  (in_data),
    .in_ctl   (in_ctl),
    .in_sync  (in_sync),
    .out_data (out_data),
    .out_ctl  (out_ctl),
    .ordered  (ordered)
);

// File: tb/lane_order_pad_tb_top.sv
module lane_order_pad_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] in_data = '0;
    logic [3:0]  in_ctl = '0;
    logic        in_sync = 1'b0;
    logic [31:0] out_data;
    logic [3:0]  out_ctl;
    logic        ordered;

    int total = 0;
    int bad   = 0;

    always #4 clk = ~clk;

    lane_order_pad dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_data  (in_data),
        .in_ctl   (in_ctl),
        .in_sync  (in_sync),
        .out_data (out_data),
        .out_ctl  (out_ctl),
        .ordered  (ordered)
    );

    // reference state, built from the requirements
    logic        m_lock = 1'b0;
    logic        m_off  = 1'b0;
    logic [15:0] m_prev_d = '0;
    logic [1:0]  m_prev_c = '0;

    // staging between driver and scoreboard
    logic [36:0] stage_exp;
    string       stage_tag;
    int          stage_seq = 0;
    int          push_seq  = 0;
    logic [36:0] exp_q[$];
    string       tag_q[$];

    always @(posedge clk) begin
        if (stage_seq != push_seq) begin
            exp_q.push_back(stage_exp);
            tag_q.push_back(stage_tag);
            push_seq = stage_seq;
        end
    end

    // monitor
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            logic [36:0] e;
            logic [36:0] a;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            a = {ordered, out_ctl, out_data};
            total++;
            if (a !== e) begin
                bad++;
                $display("FAIL %s: got ord=%0b ctl=%h data=%h, expected ord=%0b ctl=%h data=%h",
                         t, a[36], a[35:32], a[31:0], e[36], e[35:32], e[31:0]);
            end
        end
    end

    task automatic send(input logic [31:0] d, input logic [3:0] c, input logic s, input string tag);
        logic [31:0] ed;
        logic [3:0]  ec;
        @(negedge clk);
        in_data = d;
        in_ctl  = c;
        in_sync = s;
        ed = d;
        ec = c;
        if (!s) begin
            m_lock = 1'b0;
            m_off  = 1'b0;
        end else if (m_off) begin
            ed = {d[15:0], m_prev_d};
            ec = {c[1:0], m_prev_c};
            if (!m_lock && m_prev_c[0] && m_prev_d[7:0] == 8'hBC) m_lock = 1'b1;
        end else if (!m_lock) begin
            if (c[0] && d[7:0] == 8'hBC) begin
                m_lock = 1'b1;
            end else if (c[2] && d[23:16] == 8'hBC) begin
                ed = {d[15:0], 16'h0000};
                ec = {c[1:0], 2'b00};
                m_off = 1'b1;
            end
        end
        m_prev_d = d[31:16];
        m_prev_c = c[3:2];
        stage_exp = {m_lock, ec, ed};
        stage_tag = tag;
        stage_seq++;
    endtask

    task automatic check_now(input logic [36:0] e, input string tag);
        total++;
        if ({ordered, out_ctl, out_data} !== e) begin
            bad++;
            $display("FAIL %s: got %h expected %h", tag, {ordered, out_ctl, out_data}, e);
        end
    endtask

    localparam logic [31:0] ALIGN = 32'h7B4A4ABC;
    localparam logic [31:0] SWAP  = 32'h4ABC7B4A;

    initial begin
        // R10: reset state
        #1;
        check_now(37'h0, "R10 reset");
        repeat (3) @(negedge clk);
        check_now(37'h0, "R10 reset held");
        rst_n = 1'b1;

        // R2: no search without sync
        send(ALIGN, 4'b0001, 1'b0, "R2 align no sync");
        send(SWAP,  4'b0100, 1'b0, "R2 swap no sync");
        send(32'hDEADBEEF, 4'b1010, 1'b0, "R2 plain");

        // R1: flagless 0xBC ignored; then R3 lock in lane 0
        send(32'h12345678, 4'b0000, 1'b1, "R1 plain data");
        send(ALIGN, 4'b0000, 1'b1, "R1 no flag lane0");
        send(ALIGN, 4'b0001, 1'b1, "R3 lock lane0");
        send(32'h01020304, 4'b0000, 1'b1, "R9 straight");
        send(SWAP, 4'b0100, 1'b1, "R7 late pattern lane2");
        send(32'hA5A55A5A, 4'b0011, 1'b1, "R7 held");

        // R8: drop sync
        send(32'h0BADF00D, 4'b0000, 1'b0, "R8 sync loss");

        // R4/R5: half-swapped arrival
        send(SWAP, 4'b0100, 1'b1, "R4 pad insert");
        send(SWAP, 4'b0100, 1'b1, "R5 shifted lock");
        for (int i = 0; i < 6; i++)
            send({8'(4*i+3), 8'(4*i+2), 8'(4*i+1), 8'(4*i)}, 4'(i), 1'b1, "R5 shifted data");
        send(32'hBC00BC00, 4'b0000, 1'b1, "R9 shifted flagless");
        send(SWAP, 4'b0100, 1'b1, "R7 shifted late pattern");
        send(ALIGN, 4'b0001, 1'b1, "R7 shifted align");

        // R8: loss while shifted
        send(32'h11112222, 4'b0000, 1'b0, "R8 loss from shifted");
        send(32'h33334444, 4'b0000, 1'b1, "R8 searching again");

        // R6: both lanes match
        send(32'h4ABC4ABC, 4'b0101, 1'b1, "R6 lane0 priority");
        send(32'h55556666, 4'b0000, 1'b1, "R6 straight after");

        // R1: flagless 0xBC in lane 2 does not shift
        send(32'h0, 4'b0000, 1'b0, "R8 drop");
        send(SWAP, 4'b0000, 1'b1, "R1 no flag lane2");
        send(32'h77778888, 4'b0000, 1'b1, "R1 still straight");
        send(ALIGN, 4'b0001, 1'b1, "R3 relock");

        repeat (3) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule